// File: doc/BRIEF.md
# I/Q Receive Sample Serializer

This block sends pairs of 12-bit in-phase (I) and quadrature (Q) receive samples to the serial port of a signal processor. The block generates the serial clock from the master clock, along with a framing (sync) pulse and one or two data lines. A parallel sample pair is offered with a one-cycle load strobe. The pair goes out at the next frame boundary. When no new pair has arrived by then, the previous pair is sent again.

Two static selects pick the format. The layout select chooses between two arrangements. In the interleaved layout, the I word and then the Q word go out on the data pin, and a second pin flags which word is on the line. In the split layout, I goes out on the data pin and Q on the second pin at the same time. The rate select chooses either a full word rate of one word per 24 master clocks with back-to-back words, or a half word rate of one word group per 48 master clocks. At half rate, each group opens with its own sync slot and ends with an idle gap. The block goes to sleep only when both sleep inputs are high, and it always finishes the frame in progress first. On waking, it waits for a settling time that depends on the rate before it starts again with an I word.

Top module: `iq_serial_tx`

## Requirements
- R1: While asleep, and while in reset, the outputs are idle: serial clock high, and sync, data and flag low.
- R2: After the sleep state sees the sleep request removed at a clock edge, the following 32 master cycles (rate select 1) or 56 master cycles (rate select 0) stay idle. Output activity begins in the cycle after them.
- R3: At full rate only, the first frame after wake-up is preceded by one serial-clock period (two master cycles) with sync high and data and flag low.
- R4: While a bit or sync slot is active, the serial clock is high for one master cycle and then low for one master cycle. At all other times it stays high.
- R5: Each word is 12 bits, sent most significant bit first. Every bit is held for a full serial-clock period, so it is stable across the falling edge.
- R6: In the interleaved layout (layout select 0), a frame carries the I word and then the Q word on the data pin. The flag pin is 0 for the whole I word and 1 for the whole Q word.
- R7: In the split layout (layout select 1), I bits go out on the data pin and Q bits go out on the flag pin in the same slots. A frame holds one word time.
- R8: At full rate, words follow each other with no gap, 24 master cycles per word. Sync is high exactly during the last bit slot of each word.
- R9: At half rate, each word group spans 48 master cycles. The group is one sync slot with data low, then 12 bit slots, then 22 master cycles with the serial clock high and data low.
- R10: A loaded pair takes effect only at a frame boundary, and a frame always starts with I. A strobe in the boundary cycle itself is used directly. Without a new load, the last pair is repeated.
- R11: Sleep is entered only when both sleep inputs are high at the end of a frame. The frame in progress is always completed. One high sleep input has no effect.
- R12: The layout and rate selects are sampled on wake-up and at each frame boundary. A change in mid-frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_i | input | 1 | Layout select: 0 interleaved, 1 split |
| full_rate_i | input | 1 | Rate select: 1 full word rate, 0 half word rate |
| sleep_a_i | input | 1 | First sleep request |
| sleep_b_i | input | 1 | Second sleep request |
| load_i | input | 1 | One-cycle strobe that offers a new sample pair |
| smp_i_i | input | 12 | In-phase sample |
| smp_q_i | input | 12 | Quadrature sample |
| sclk_o | output | 1 | Serial clock (half master rate while active, high when idle) |
| sync_o | output | 1 | Framing pulse |
| data_o | output | 1 | Serial data (I, or I then Q) |
| iq_o | output | 1 | Word flag (interleaved) or Q data (split) |

## Verification
All four combinations of layout and rate are run with asymmetric sample patterns. A swapped or bit-reversed word, or a wrong flag polarity, then shows up as a mismatch. Pairs are loaded in mid-frame and again left out for several frames, which tells a boundary-aligned update apart from an immediate one and confirms that the last pair is repeated. The selects are changed in the middle of a frame. Only one sleep input is raised first and then both, so that sleep entry is shown to wait for the frame end. Waking at each rate separates the two latencies and shows whether the full-rate preamble is present.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP,
    ST_WAKE,
    ST_PRE,
    ST_RUN
  } iqs_state_e;

  // split: I and Q on separate pins; full: full word rate
  typedef struct packed {
    logic split;
    logic full;
  } iqs_cfg_t;

  // master cycles of settling after sleep
  function automatic int unsigned wake_cycles(input logic full,
                                              input int unsigned wf,
                                              input int unsigned wh);
    return full ? wf : wh;
  endfunction

  // last slot index inside one word group
  function automatic int unsigned slot_last(input logic full, input int unsigned ww);
    return full ? (ww - 1) : (2 * ww - 1);
  endfunction

  // last word index inside one frame
  function automatic logic word_last(input logic split);
    return split ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/iqs_seq.sv
module iqs_seq
  import iqs_pkg::*;
#(
  parameter int unsigned WORD_W    = 12,
  parameter int unsigned WAKE_FULL = 32,
  parameter int unsigned WAKE_HALF = 56,
  localparam int unsigned SLOT_W   = $clog2(2 * WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  iqs_cfg_t          cfg,
  output iqs_state_e        state,
  output logic              ph,
  output logic [SLOT_W-1:0] slot,
  output logic              word,
  output logic              frame_go,
  output logic              frame_end,
  output logic              cfg_take
);

  localparam int unsigned WAKE_MAX = (WAKE_FULL > WAKE_HALF) ? WAKE_FULL : WAKE_HALF;
  localparam int unsigned CNT_W    = $clog2(WAKE_MAX + 1);

  iqs_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ph_q;
  logic              word_q;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_end;
  logic              wake_done;
  logic              wake_go;

  assign slot_end  = (slot_q == SLOT_W'(slot_last(cfg.full, WORD_W)));
  assign frame_end = (st_q == ST_RUN) && ph_q && slot_end && (word_q == word_last(cfg.split));
  assign wake_done = (st_q == ST_WAKE) &&
                     (cnt_q == CNT_W'(wake_cycles(cfg.full, WAKE_FULL, WAKE_HALF) - 1));
  assign wake_go   = (st_q == ST_SLEEP) && !sleep_req;
  assign frame_go  = (wake_done && !cfg.full) || ((st_q == ST_PRE) && ph_q) ||
                     (frame_end && !sleep_req);
  assign cfg_take  = wake_go || (frame_end && !sleep_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SLEEP;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      slot_q <= '0;
      word_q <= 1'b0;
    end else if (frame_go) begin
      st_q   <= ST_RUN;
      ph_q   <= 1'b0;
      slot_q <= '0;
      word_q <= 1'b0;
    end else begin
      case (st_q)
        ST_SLEEP: begin
          if (!sleep_req) begin
            st_q  <= ST_WAKE;
            cnt_q <= '0;
          end
        end
        ST_WAKE: begin
          cnt_q <= cnt_q + 1'b1;
          if (wake_done) begin
            st_q <= ST_PRE;
            ph_q <= 1'b0;
          end
        end
        ST_PRE: ph_q <= ~ph_q;
        default: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (slot_end) begin
              slot_q <= '0;
              if (frame_end) st_q <= ST_SLEEP;
              else           word_q <= 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign state = st_q;
  assign ph    = ph_q;
  assign slot  = slot_q;
  assign word  = word_q;

endmodule

// File: rtl/iqs_pair_buf.sv
module iqs_pair_buf
  import iqs_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] in_i,
  input  logic [WORD_W-1:0] in_q,
  input  logic              take,
  input  logic              cfg_take,
  input  logic              split_in,
  input  logic              full_in,
  output logic [WORD_W-1:0] cur_i,
  output logic [WORD_W-1:0] cur_q,
  output iqs_cfg_t          cfg
);

  logic [WORD_W-1:0] pend_i_q, pend_q_q, cur_i_q, cur_q_q;
  logic              pend_vld_q;
  iqs_cfg_t          cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_i_q   <= '0;
      pend_q_q   <= '0;
      pend_vld_q <= 1'b0;
      cur_i_q    <= '0;
      cur_q_q    <= '0;
    end else if (take) begin
      if (load) begin
        cur_i_q <= in_i;
        cur_q_q <= in_q;
      end else if (pend_vld_q) begin
        cur_i_q <= pend_i_q;
        cur_q_q <= pend_q_q;
      end
      pend_vld_q <= 1'b0;
    end else if (load) begin
      pend_i_q   <= in_i;
      pend_q_q   <= in_q;
      pend_vld_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_take) cfg_q <= '{split: split_in, full: full_in};
  end

  assign cur_i = cur_i_q;
  assign cur_q = cur_q_q;
  assign cfg   = cfg_q;

endmodule

// File: rtl/iqs_fmt.sv
module iqs_fmt
  import iqs_pkg::*;
#(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned SLOT_W = $clog2(2 * WORD_W)
) (
  input  iqs_state_e        state,
  input  logic              ph,
  input  logic [SLOT_W-1:0] slot,
  input  logic              word,
  input  iqs_cfg_t          cfg,
  input  logic [WORD_W-1:0] cur_i,
  input  logic [WORD_W-1:0] cur_q,
  output logic              sclk,
  output logic              sync,
  output logic              data,
  output logic              iq
);

  // bit number k counts from the most significant bit
  function automatic logic msb_pick(input logic [WORD_W-1:0] v, input logic [SLOT_W-1:0] k);
    logic r;
    r = 1'b0;
    for (int n = 0; n < WORD_W; n++) begin
      if (SLOT_W'(n) == k) r = v[WORD_W-1-n];
    end
    return r;
  endfunction

  logic [WORD_W-1:0] wsel;
  logic [SLOT_W-1:0] bnum;
  logic              bit_slot;
  logic              wflag;

  always_comb begin
    wsel     = (word && !cfg.split) ? cur_q : cur_i;
    wflag    = word && !cfg.split;
    bit_slot = 1'b0;
    bnum     = '0;
    sclk     = 1'b1;
    sync     = 1'b0;
    data     = 1'b0;
    iq       = 1'b0;
    case (state)
      ST_PRE: begin
        sclk = ~ph;
        sync = 1'b1;
      end
      ST_RUN: begin
        if (cfg.full) begin
          sclk     = ~ph;
          sync     = (slot == SLOT_W'(WORD_W - 1));
          bit_slot = 1'b1;
          bnum     = slot;
        end else begin
          iq = wflag;
          if (slot == '0) begin
            sclk = ~ph;
            sync = 1'b1;
          end else if (slot <= SLOT_W'(WORD_W)) begin
            sclk     = ~ph;
            bit_slot = 1'b1;
            bnum     = slot - 1'b1;
          end
        end
        if (bit_slot) begin
          data = msb_pick(wsel, bnum);
          iq   = cfg.split ? msb_pick(cur_q, bnum) : wflag;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/iq_serial_tx.sv
module iq_serial_tx
  import iqs_pkg::*;
#(
  parameter int unsigned WORD_W    = 12,
  parameter int unsigned WAKE_FULL = 32,
  parameter int unsigned WAKE_HALF = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_i,
  input  logic              full_rate_i,
  input  logic              sleep_a_i,
  input  logic              sleep_b_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] smp_i_i,
  input  logic [WORD_W-1:0] smp_q_i,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              data_o,
  output logic              iq_o
);

  localparam int unsigned SLOT_W = $clog2(2 * WORD_W);

  iqs_state_e        state;
  iqs_cfg_t          cfg;
  logic              ph, word;
  logic [SLOT_W-1:0] slot;
  logic              frame_go, frame_end, cfg_take;
  logic [WORD_W-1:0] cur_i, cur_q;

  // named events for the checker
  logic sleep_req;
  logic asleep;
  assign sleep_req = sleep_a_i && sleep_b_i;
  assign asleep    = (state == ST_SLEEP);

  iqs_seq #(
    .WORD_W   (WORD_W),
    .WAKE_FULL(WAKE_FULL),
    .WAKE_HALF(WAKE_HALF)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_req(sleep_req),
    .cfg      (cfg),
    .state    (state),
    .ph       (ph),
    .slot     (slot),
    .word     (word),
    .frame_go (frame_go),
    .frame_end(frame_end),
    .cfg_take (cfg_take)
  );

  iqs_pair_buf #(.WORD_W(WORD_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_i),
    .in_i    (smp_i_i),
    .in_q    (smp_q_i),
    .take    (frame_go),
    .cfg_take(cfg_take),
    .split_in(split_i),
    .full_in (full_rate_i),
    .cur_i   (cur_i),
    .cur_q   (cur_q),
    .cfg     (cfg)
  );

  iqs_fmt #(.WORD_W(WORD_W)) u_fmt (
    .state(state),
    .ph   (ph),
    .slot (slot),
    .word (word),
    .cfg  (cfg),
    .cur_i(cur_i),
    .cur_q(cur_q),
    .sclk (sclk_o),
    .sync (sync_o),
    .data (data_o),
    .iq   (iq_o)
  );

endmodule

// File: rtl/iq_serial_tx_chk.sv
module iq_serial_tx_chk #(
  parameter int unsigned WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              sync,
  input logic              data,
  input logic              iq,
  input logic              asleep,
  input logic              frame_go,
  input logic              frame_end,
  input logic [WORD_W-1:0] cur_i,
  input logic [WORD_W-1:0] cur_q
);

  assert_idle_asleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (sclk && !sync && !data && !iq));

  assert_sclk_low_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |=> sclk);

  assert_bit_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> ($stable(data) && $stable(iq)));

  assert_pair_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_go |=> ($stable(cur_i) && $stable(cur_q)));

  assert_sleep_after_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(frame_end));

endmodule

bind iq_serial_tx iq_serial_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk_o),
  .sync     (sync_o),
  .data     (data_o),
  .iq       (iq_o),
  .asleep   (asleep),
  .frame_go (frame_go),
  .frame_end(frame_end),
  .cur_i    (cur_i),
  .cur_q    (cur_q)
);

// File: tb/test_iq_serial_tx.sv
`timescale 1ns/1ps
module test_iq_serial_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        split = 1'b0, full = 1'b1, sa = 1'b1, sb = 1'b1, ld = 1'b0;
  logic [11:0] di = '0, dq = '0;
  logic        sclk, sync, data, iq;

  always #4 clk = ~clk;

  iq_serial_tx i_iq_serial_tx (
    .clk(clk), .rst_n(rst_n), .split_i(split), .full_rate_i(full),
    .sleep_a_i(sa), .sleep_b_i(sb), .load_i(ld), .smp_i_i(di), .smp_q_i(dq),
    .sclk_o(sclk), .sync_o(sync), .data_o(data), .iq_o(iq)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string tag = "R1 reset idle";

  // ---------------- reference model: queue of expected output tuples
  logic [3:0]  exp_q[$];
  int          m_st;          // 0 asleep, 1 woke, 2 preamble sent, 3 frame sent
  logic        m_split, m_full, m_pv;
  logic [11:0] m_ci, m_cq, m_pi, m_pq;

  task automatic push_e(input logic s, input logic y, input logic d, input logic q);
    exp_q.push_back({s, y, d, q});
  endtask

  task automatic push_idle(input int n);
    for (int k = 0; k < n; k++) push_e(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic push_frame();
    int nw;
    nw = m_split ? 1 : 2;
    for (int w = 0; w < nw; w++) begin
      logic [11:0] wv;
      logic        fl;
      wv = (w == 0) ? m_ci : m_cq;
      fl = !m_split && (w == 1);
      if (!m_full) begin
        push_e(1'b1, 1'b1, 1'b0, fl);
        push_e(1'b0, 1'b1, 1'b0, fl);
      end
      for (int b = 0; b < 12; b++)
        for (int p = 0; p < 2; p++)
          push_e(p == 0, m_full && (b == 11), wv[11-b], m_split ? m_cq[11-b] : fl);
      if (!m_full)
        for (int k = 0; k < 22; k++) push_e(1'b1, 1'b0, 1'b0, fl);
    end
  endtask

  task automatic start_frame(output bit took);
    if (ld) begin
      m_ci = di; m_cq = dq;
    end else if (m_pv) begin
      m_ci = m_pi; m_cq = m_pq;
    end
    m_pv = 1'b0;
    took = 1'b1;
    push_frame();
    m_st = 3;
  endtask

  task automatic m_next(output bit took);
    took = 1'b0;
    case (m_st)
      0: if (!(sa && sb)) begin
           m_full = full; m_split = split;
           push_idle(full ? 32 : 56);
           m_st = 1;
         end else push_idle(1);
      1: if (m_full) begin
           push_e(1'b1, 1'b1, 1'b0, 1'b0);
           push_e(1'b0, 1'b1, 1'b0, 1'b0);
           m_st = 2;
         end else start_frame(took);
      2: start_frame(took);
      default:
         if (sa && sb) begin
           push_idle(1);
           m_st = 0;
         end else begin
           m_full = full; m_split = split;
           start_frame(took);
         end
    endcase
  endtask

  always @(posedge clk) begin
    bit took;
    if (!rst_n) begin
      exp_q.delete();
      push_idle(1);
      m_st = 0; m_split = 1'b0; m_full = 1'b0; m_pv = 1'b0;
      m_ci = '0; m_cq = '0; m_pi = '0; m_pq = '0;
    end else begin
      took = 1'b0;
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      if (exp_q.size() == 0) m_next(took);
      if (!took && ld) begin
        m_pi = di; m_pq = dq; m_pv = 1'b1;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: actual %b expected <none>", tag, {sclk, sync, data, iq});
      end else if ({sclk, sync, data, iq} !== exp_q[0]) begin
        n_bad++;
        $display("FAIL %s: actual sclk/sync/data/iq=%b expected %b at %0t",
                 tag, {sclk, sync, data, iq}, exp_q[0], $time);
      end
    end
  end

  // ---------------- stimulus
  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_pair(input logic [11:0] a, input logic [11:0] b);
    @(negedge clk);
    di = a; dq = b; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0; di = 12'h000; dq = 12'h000;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    n_cmp++;
    if ({sclk, sync, data, iq} !== 4'b1000) begin
      n_bad++;
      $display("FAIL R1 reset: actual %b expected 1000", {sclk, sync, data, iq});
    end
    rst_n = 1'b1;
    tag = "R1 asleep idle";
    cycles(10);
    load_pair(12'hA5C, 12'h3C7);
    tag = "R2 R3 R5 R6 R8 wake full rate interleaved";
    @(negedge clk); sa = 1'b0;
    cycles(130);
    tag = "R10 mid-frame load then repeat";
    load_pair(12'h813, 12'hF0E);
    cycles(160);
    tag = "R7 R12 split layout full rate";
    @(negedge clk); split = 1'b1;
    cycles(20);
    load_pair(12'h001, 12'h800);
    cycles(120);
    tag = "R9 R7 split layout half rate";
    @(negedge clk); full = 1'b0;
    load_pair(12'h6B2, 12'h94D);
    cycles(200);
    tag = "R9 R6 interleaved half rate";
    @(negedge clk); split = 1'b0;
    cycles(250);
    tag = "R11 one sleep input has no effect";
    @(negedge clk); sa = 1'b1; sb = 1'b0;
    cycles(120);
    tag = "R11 sleep after frame end";
    @(negedge clk); sb = 1'b1;
    cycles(200);
    tag = "R2 R9 wake half rate";
    load_pair(12'hFFF, 12'h000);
    @(negedge clk); sb = 1'b0;
    cycles(300);
    tag = "R11 R1 sleep again";
    @(negedge clk); sb = 1'b1; full = 1'b1; split = 1'b1;
    cycles(200);
    tag = "R3 R7 R8 wake full rate split";
    @(negedge clk); sa = 1'b0;
    load_pair(12'h5A5, 12'hC33);
    cycles(200);
    tag = "R4 R12 back to interleaved full rate";
    @(negedge clk); split = 1'b0;
    cycles(200);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule